// File: doc/BRIEF.md
# Match/Capture Timer

This block is a general-purpose timer for a peripheral subsystem. A free-running count advances either on every enabled clock cycle or on a chosen edge of one capture input, which then acts as an external count clock. Four compare channels watch the count. When the count reaches a channel's value, the channel can flag an interrupt, reset or stop the count, and drive its match output low, high, toggled or unchanged. Each match output fans out to several identical pins.

Four capture channels each pick one of several candidate pins and synchronize it. On a selected edge they copy the running count into their own capture register and can flag an interrupt. Software programs all of this through a small word-addressed register port, and it reads back the count, the compare and capture values and the sticky interrupt flags.

Register word addresses: 0 control, 1 count, 2 interrupt flags, 3 match control, 4 match action, 5 capture control, 6 capture pin select, 8 to 11 compare values 0 to 3, 12 to 15 capture values 0 to 3 (read only).

Top module: `tmr_match_capture`

## Requirements
- R1: With control bit 0 (run) set, bit 1 (hold) clear and bit 2 (external source) clear, the count rises by one on every clock edge and wraps from all-ones to zero.
- R2: With bit 2 set, the count rises by one for each rising edge (bit 3 clear) or each falling edge (bit 3 set) of capture channel bits [5:4]'s selected pin, and is otherwise unchanged. The new count is visible after the third rising clock edge that follows the pin change.
- R3: When the count is loaded with a value equal to compare value i, whether by counting or by a write, exactly one match event for i follows in the next cycle. If match control bit 3i is set, that event sets flag bit i.
- R4: A match event applies the 2-bit action at bits [2i+1:2i] of address 4: 00 no change, 01 drive low, 10 drive high, 11 toggle. Bit 16+i of address 4 reads back the current state of match output i.
- R5: All MAT_FAN pins of match output i, at mat_pin_o[i*MAT_FAN +: MAT_FAN], always carry the same value.
- R6: If match control bit 3i+1 is set, a count step taken while the count equals compare value i loads zero instead of count+1.
- R7: If match control bit 3i+2 is set, a match event on i clears the run bit and blocks the step in that cycle, so the count rests on the compare value.
- R8: Capture channel c loads its capture register with the count of the cycle in which a synchronized edge is seen. Rising edges are enabled by bit 3c, falling edges by bit 3c+1 (both bits set means either edge), and bit 3c+2 enables setting flag bit N_MATCH+c. A pin edge is captured at the third rising clock edge after the change.
- R9: Bit c*CAP_PINS+p of address 6 enables pin p for channel c. The lowest enabled pin drives the channel and the other pins are ignored. With no pin enabled, the channel sees a constant low.
- R10: Flags are sticky. Writing 1 to a bit at address 2 clears it and writing 0 has no effect. A flag set in the same cycle as its clear stays set. irq_o is the OR of all flags.
- R11: While hold is set, the count is zero from the next edge on, count writes are ignored and no step is taken.
- R12: A write to address 1 while hold is clear loads the count, and the new value reads back from the next cycle.
- R13: After reset, all registers, flags, match outputs and irq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cap_pin_i | input | N_CAP*CAP_PINS | Candidate capture pins, channel-major |
| mat_pin_o | output | N_MATCH*MAT_FAN | Match output pins, channel-major |
| irq_o | output | 1 | Interrupt request |

## Verification
A match event that sets a flag can land in the same cycle as a software write clearing that flag. The bench writes a count equal to compare value 0, then issues the W1C write on the very next clock, which is the cycle the match event is live. It then expects the flag to read as 1, and expects a later plain clear to drop both the flag and irq_o.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TOG  = 2'b11
  } mat_act_e;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_COUNT  = 4'd1;
  localparam logic [3:0] A_FLAGS  = 4'd2;
  localparam logic [3:0] A_MCTRL  = 4'd3;
  localparam logic [3:0] A_ACTION = 4'd4;
  localparam logic [3:0] A_CCTRL  = 4'd5;
  localparam logic [3:0] A_PINSEL = 4'd6;
  localparam logic [3:0] A_MR0    = 4'd8;
  localparam logic [3:0] A_CR0    = 4'd12;

  // new level of a match output after an event
  function automatic logic apply_act(mat_act_e a, logic cur);
    case (a)
      ACT_NONE: return cur;
      ACT_CLR:  return 1'b0;
      ACT_SET:  return 1'b1;
      default:  return ~cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             fresh,
  input  logic [CNT_W-1:0] match_val,
  input  mat_act_e         act,
  output logic             eq,
  output logic             hit,
  output logic             mat_q
);

  assign eq  = (count == match_val);
  assign hit = eq && fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mat_q <= 1'b0;
    else if (hit) mat_q <= apply_act(act, mat_q);
  end

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_TOG) |=> (mat_q != $past(mat_q)));
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_SET) |=> mat_q);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act == ACT_CLR) |=> !mat_q);
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(mat_q));

endmodule

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan #(
  parameter int CNT_W = 32,
  parameter int PINS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  pins,
  input  logic [PINS-1:0]  pin_en,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic [CNT_W-1:0] count,
  output logic             edge_rise,
  output logic             edge_fall,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val
);

  logic [PINS-1:0] sync1, sync2;
  logic            sel, prev;

  // lowest enabled pin wins; none enabled reads as low
  function automatic logic pick_lowest(logic [PINS-1:0] en, logic [PINS-1:0] lvl);
    logic r;
    r = 1'b0;
    for (int i = PINS - 1; i >= 0; i--) begin
      if (en[i]) r = lvl[i];
    end
    return r;
  endfunction

  assign sel       = pick_lowest(pin_en, sync2);
  assign edge_rise = sel && !prev;
  assign edge_fall = !sel && prev;
  assign cap_evt   = (edge_rise && rise_en) || (edge_fall && fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= 1'b0;
      cap_val <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      prev  <= sel;
      if (cap_evt) cap_val <= count;
    end
  end

  a_r8_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(count)));
  a_r8_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));

endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int N_MATCH  = 4,
  parameter int N_CAP    = 4,
  parameter int CAP_PINS = 2,
  parameter int MAT_FAN  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [3:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic [N_CAP*CAP_PINS-1:0]   cap_pin_i,
  output logic [N_MATCH*MAT_FAN-1:0]  mat_pin_o,
  output logic                        irq_o
);

  localparam int CH_W  = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int NFLAG = N_MATCH + N_CAP;

  // control
  logic            ctrl_run, ctrl_hold, ctrl_ext, ctrl_ext_fall;
  logic [CH_W-1:0] ctrl_ch;
  // count
  logic [CNT_W-1:0] count;
  logic             fresh;
  // match setup
  logic [N_MATCH-1:0] mr_ie, mr_rst, mr_stop;
  mat_act_e           mr_act [N_MATCH];
  logic [CNT_W-1:0]   mr_val [N_MATCH];
  // capture setup
  logic [N_CAP-1:0]    cap_rise_en, cap_fall_en, cap_ie;
  logic [CAP_PINS-1:0] pin_en [N_CAP];
  // flags
  logic [NFLAG-1:0] flags;

  // internal events
  logic [N_MATCH-1:0] m_eq, m_hit, mat_q;
  logic [N_CAP-1:0]   c_rise, c_fall, c_evt;
  logic [CNT_W-1:0]   cap_val [N_CAP];
  logic ext_edge, rst_hit, stop_evt, tick;
  logic wr_ctrl, wr_count, wr_flags, wr_mctrl, wr_action, wr_cctrl, wr_pinsel;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_count  = reg_wr && (reg_addr == A_COUNT) && !ctrl_hold;
  assign wr_flags  = reg_wr && (reg_addr == A_FLAGS);
  assign wr_mctrl  = reg_wr && (reg_addr == A_MCTRL);
  assign wr_action = reg_wr && (reg_addr == A_ACTION);
  assign wr_cctrl  = reg_wr && (reg_addr == A_CCTRL);
  assign wr_pinsel = reg_wr && (reg_addr == A_PINSEL);

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur, logic to_zero);
    return to_zero ? '0 : cur + 1'b1;
  endfunction

  // ---------------- channels ----------------
  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    tmr_match_chan #(.CNT_W(CNT_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (count),
      .fresh     (fresh),
      .match_val (mr_val[i]),
      .act       (mr_act[i]),
      .eq        (m_eq[i]),
      .hit       (m_hit[i]),
      .mat_q     (mat_q[i])
    );
    for (genvar f = 0; f < MAT_FAN; f++) begin : g_fan
      assign mat_pin_o[i*MAT_FAN + f] = mat_q[i];
    end
  end

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    tmr_cap_chan #(.CNT_W(CNT_W), .PINS(CAP_PINS)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins      (cap_pin_i[c*CAP_PINS +: CAP_PINS]),
      .pin_en    (pin_en[c]),
      .rise_en   (cap_rise_en[c]),
      .fall_en   (cap_fall_en[c]),
      .count     (count),
      .edge_rise (c_rise[c]),
      .edge_fall (c_fall[c]),
      .cap_evt   (c_evt[c]),
      .cap_val   (cap_val[c])
    );
  end

  // ---------------- count path ----------------
  assign ext_edge = ctrl_ext_fall ? c_fall[ctrl_ch] : c_rise[ctrl_ch];
  assign rst_hit  = |(m_eq & mr_rst);
  assign stop_evt = |(m_hit & mr_stop);
  assign tick     = ctrl_run && !ctrl_hold && !stop_evt && (!ctrl_ext || ext_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (ctrl_hold) begin
        count <= '0;
      end else if (wr_count) begin
        count <= reg_wdata[CNT_W-1:0];
        fresh <= 1'b1;
      end else if (tick) begin
        count <= next_count(count, rst_hit);
        fresh <= 1'b1;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_run      <= 1'b0;
      ctrl_hold     <= 1'b0;
      ctrl_ext      <= 1'b0;
      ctrl_ext_fall <= 1'b0;
      ctrl_ch       <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_run      <= reg_wdata[0];
        ctrl_hold     <= reg_wdata[1];
        ctrl_ext      <= reg_wdata[2];
        ctrl_ext_fall <= reg_wdata[3];
        ctrl_ch       <= reg_wdata[4 +: CH_W];
      end
      if (stop_evt) ctrl_run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_ie   <= '0;
      mr_rst  <= '0;
      mr_stop <= '0;
      for (int i = 0; i < N_MATCH; i++) begin
        mr_act[i] <= ACT_NONE;
        mr_val[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_MATCH; i++) begin
        if (wr_mctrl) begin
          mr_ie[i]   <= reg_wdata[3*i];
          mr_rst[i]  <= reg_wdata[3*i + 1];
          mr_stop[i] <= reg_wdata[3*i + 2];
        end
        if (wr_action) mr_act[i] <= mat_act_e'(reg_wdata[2*i +: 2]);
        if (reg_wr && reg_addr == 4'(A_MR0 + i)) mr_val[i] <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rise_en <= '0;
      cap_fall_en <= '0;
      cap_ie      <= '0;
      for (int c = 0; c < N_CAP; c++) pin_en[c] <= '0;
    end else begin
      for (int c = 0; c < N_CAP; c++) begin
        if (wr_cctrl) begin
          cap_rise_en[c] <= reg_wdata[3*c];
          cap_fall_en[c] <= reg_wdata[3*c + 1];
          cap_ie[c]      <= reg_wdata[3*c + 2];
        end
        if (wr_pinsel) pin_en[c] <= reg_wdata[c*CAP_PINS +: CAP_PINS];
      end
    end
  end

  // sticky flags: set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~(wr_flags ? reg_wdata[NFLAG-1:0] : '0))
                         | {c_evt & cap_ie, m_hit & mr_ie};
  end

  assign irq_o = |flags;

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]         = ctrl_run;
        reg_rdata[1]         = ctrl_hold;
        reg_rdata[2]         = ctrl_ext;
        reg_rdata[3]         = ctrl_ext_fall;
        reg_rdata[4 +: CH_W] = ctrl_ch;
      end
      A_COUNT: reg_rdata = 32'(count);
      A_FLAGS: reg_rdata[NFLAG-1:0] = flags;
      A_MCTRL: begin
        for (int i = 0; i < N_MATCH; i++) begin
          reg_rdata[3*i]     = mr_ie[i];
          reg_rdata[3*i + 1] = mr_rst[i];
          reg_rdata[3*i + 2] = mr_stop[i];
        end
      end
      A_ACTION: begin
        for (int i = 0; i < N_MATCH; i++) begin
          reg_rdata[2*i +: 2] = mr_act[i];
          reg_rdata[16 + i]   = mat_q[i];
        end
      end
      A_CCTRL: begin
        for (int c = 0; c < N_CAP; c++) begin
          reg_rdata[3*c]     = cap_rise_en[c];
          reg_rdata[3*c + 1] = cap_fall_en[c];
          reg_rdata[3*c + 2] = cap_ie[c];
        end
      end
      A_PINSEL: begin
        for (int c = 0; c < N_CAP; c++) reg_rdata[c*CAP_PINS +: CAP_PINS] = pin_en[c];
      end
      default: begin
        for (int i = 0; i < N_MATCH; i++)
          if (reg_addr == 4'(A_MR0 + i)) reg_rdata = 32'(mr_val[i]);
        for (int c = 0; c < N_CAP; c++)
          if (reg_addr == 4'(A_CR0 + c)) reg_rdata = 32'(cap_val[c]);
      end
    endcase
  end

  // ---------------- assertions ----------------
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rst_hit && !wr_count) |=> (count == $past(count) + 1'b1));
  a_r2_ext_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ext && !ext_edge && !wr_count && !ctrl_hold) |=> $stable(count));
  a_r6_reset_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rst_hit && !wr_count) |=> (count == '0));
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !wr_count) |=> (!ctrl_run && $stable(count)));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((flags & $past(flags)) == $past(flags)));
  a_r11_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hold |=> (count == '0 && !fresh));

endmodule

// File: tb/tmr_match_capture_test.sv
module tmr_match_capture_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  cap_pin_i = '0;
  logic [7:0]  mat_pin_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_match_capture uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin_i(cap_pin_i),
    .mat_pin_o(mat_pin_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v);  check("R13 ctrl", v, 0);
    rd(4'd1, v);  check("R13 count", v, 0);
    rd(4'd2, v);  check("R13 flags", v, 0);
    check("R13 match pins", {24'd0, mat_pin_o}, 0);
    check("R13 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(4'd1, 32'd100);
    rd(4'd1, v);  check("R12 count load", v, 100);
    wr(4'd0, 32'h1);
    wait_cycles(10);
    rd(4'd1, v);  check("R1 ten steps", v, 110);
    wr(4'd0, 32'h3);
    wait_cycles(3);
    rd(4'd1, v);  check("R11 hold zero", v, 0);
    wr(4'd1, 32'd55);
    wait_cycles(2);
    rd(4'd1, v);  check("R11 write ignored in hold", v, 0);
    wr(4'd0, 32'h0);
    wr(4'd1, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    wait_cycles(3);
    rd(4'd1, v);  check("R1 wrap", v, 1);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(4'(8 + i), 32'd10);
    wr(4'd3, 32'h1);
    wr(4'd4, 32'hAA);
    wr(4'd1, 32'd5);
    wr(4'd1, 32'd10);
    wait_cycles(1);
    check("R5 all pins high", {24'd0, mat_pin_o}, 32'hFF);
    rd(4'd2, v);  check("R3 match flag", v, 32'h1);
    check("R10 irq follows flag", {31'd0, irq_o}, 1);
    wr(4'd2, 32'h0);
    rd(4'd2, v);  check("R10 write zero no effect", v, 32'h1);
    wr(4'd2, 32'h1);
    rd(4'd2, v);  check("R10 w1c", v, 0);
    check("R10 irq low", {31'd0, irq_o}, 0);
    wr(4'd4, 32'h27);
    wr(4'd1, 32'd5);
    wr(4'd1, 32'd10);
    wait_cycles(1);
    check("R4 actions tog/low/high/none", {24'd0, mat_pin_o}, 32'hF0);
    rd(4'd4, v);  check("R4 readback", v, 32'h000C_0027);
    wr(4'd2, 32'hFF);
  endtask

  task automatic t_rst_stop();
    logic [31:0] v;
    wr(4'd9, 32'd20);
    wr(4'd3, 32'h10);
    wr(4'd1, 32'd15);
    wr(4'd0, 32'h1);
    wait_cycles(7);
    rd(4'd1, v);  check("R6 reset on match", v, 1);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h100);
    wr(4'd10, 32'd30);
    wr(4'd1, 32'd25);
    wr(4'd0, 32'h1);
    wait_cycles(10);
    rd(4'd1, v);  check("R7 count rests on match", v, 30);
    rd(4'd0, v);  check("R7 run cleared", v & 32'h1, 0);
    wr(4'd3, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h1234);
    wr(4'd6, 32'h3);
    wr(4'd5, 32'h5);
    @(negedge clk); cap_pin_i[1] = 1'b1;
    wait_cycles(4);
    rd(4'd12, v); check("R9 higher pin ignored", v, 0);
    rd(4'd2, v);  check("R9 no flag from ignored pin", v, 0);
    @(negedge clk); cap_pin_i[0] = 1'b1;
    wait_cycles(3);
    rd(4'd12, v); check("R8 rising capture", v, 32'h1234);
    rd(4'd2, v);  check("R8 capture flag", v, 32'h10);
    wr(4'd2, 32'h10);
    wr(4'd1, 32'h55);
    wr(4'd5, 32'h2);
    @(negedge clk); cap_pin_i[0] = 1'b0;
    wait_cycles(3);
    rd(4'd12, v); check("R8 falling capture", v, 32'h55);
    wr(4'd6, 32'hB);
    wr(4'd5, 32'h1A);
    wr(4'd1, 32'h77);
    @(negedge clk); cap_pin_i[3] = 1'b1;
    wait_cycles(3);
    rd(4'd13, v); check("R8 both edges rise", v, 32'h77);
    wr(4'd1, 32'h88);
    @(negedge clk); cap_pin_i[3] = 1'b0;
    wait_cycles(3);
    rd(4'd13, v); check("R8 both edges fall", v, 32'h88);
    wr(4'd5, 32'h5A);
    @(negedge clk); cap_pin_i[4] = 1'b1;
    wait_cycles(4);
    rd(4'd14, v); check("R9 no pin enabled", v, 0);
    @(negedge clk); cap_pin_i[4] = 1'b0; cap_pin_i[1] = 1'b0;
    wr(4'd5, 32'h0);
    wr(4'd2, 32'hFF);
  endtask

  task automatic pulse();
    @(negedge clk); cap_pin_i[6] = 1'b1;
    wait_cycles(3);
    cap_pin_i[6] = 1'b0;
    wait_cycles(3);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    wr(4'd6, 32'h40);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h35);
    wait_cycles(5);
    rd(4'd1, v);  check("R2 no edge no count", v, 0);
    @(negedge clk); cap_pin_i[6] = 1'b1;
    wait_cycles(2);
    rd(4'd1, v);  check("R2 latency before", v, 0);
    wait_cycles(1);
    rd(4'd1, v);  check("R2 latency after", v, 1);
    wait_cycles(2);
    cap_pin_i[6] = 1'b0;
    wait_cycles(3);
    for (int k = 0; k < 4; k++) pulse();
    rd(4'd1, v);  check("R2 rising count", v, 5);
    wr(4'd0, 32'h3D);
    pulse();
    pulse();
    rd(4'd1, v);  check("R2 falling count", v, 7);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(4'd3, 32'h1);
    wr(4'd8, 32'd40);
    wr(4'd2, 32'hFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'd40;
    @(negedge clk);
    reg_addr = 4'd2; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(4'd2, v);  check("R10 set beats clear", v & 32'h1, 32'h1);
    check("R3 irq on match", {31'd0, irq_o}, 1);
    wr(4'd2, 32'h1);
    rd(4'd2, v);  check("R10 later clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_match();
    t_rst_stop();
    t_capture();
    t_ext();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule